// File: doc/BRIEF.md
# Five-bit code-group receive decoder

This block sits behind a line receiver whose clock recovery, NRZI decoding and descrambling are already done. Each receive clock it accepts up to two recovered line bits plus a count of how many of them are real. It shifts those bits into a ten-bit history and waits for an idle code followed by a J code. That boundary fixes where each five-bit code group starts. From then on it turns code groups back into four-bit values and presents them on a nibble-wide receive port. The port carries a data-valid flag, an error flag, a nibble clock enable and a carrier-sense flag.

A start that is not a clean J then K is reported as false carrier. The block also reports invalid codes inside a frame and a frame that stops with idle instead of the T/R end delimiter. The nibble port runs one code group behind the line. A code is only classified once its successor is known, so an end delimiter never shows up as data and a J never shows up before the K confirms it.

Top module: `codeGroupRx`

## Requirements
- R1: Each clock the block consumes exactly `bitCount` bits (0, 1 or 2). With a count of 1 the bit is `lineBits[1]`. With a count of 2, `lineBits[1]` is the earlier bit and `lineBits[0]` the later. Every code group is sent most significant bit first.
- R2: Outside a frame, the history is checked after each bit. A frame begins when the last ten bits are idle (11111) followed by J (11000). If the following code is K (10001), two slots of 0x5 with data-valid high and error low are presented, and data-valid first rises on a 0x5 slot.
- R3: Inside a frame, data codes map to nibbles 0x0..0xF as follows: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Each appears as one slot with data-valid high and error low.
- R4: Inside a frame, any other code that is not part of an end sequence (for example H = 00100) yields one slot with data-valid and error both high and nibble 0x0.
- R5: T (01101) followed by R (00111) ends the frame with a single slot of data-valid low, error low, nibble 0x0. Neither code is output as data, and carrier sense drops in that same cycle.
- R6: Outside a frame, a zero bit completes a carrier event when another zero lies two to nine bits earlier. If that event is not idle-then-J, or if J is not followed by K, a slot of data-valid low, error high, nibble 0xE is output. The block repeats the slot for each further complete code group. Carrier sense stays high until the last ten bits are all ones, and the next clock presents a slot with everything cleared.
- R7: Two idle codes in a row inside a frame give one slot with data-valid and error high and nibble 0x0. The next clock presents a slot with data-valid low.
- R8: After an end delimiter the history counts as all idle, so a new frame is found after zero to nine (or more) extra idle bits.
- R9: `nibbleCe` is high for exactly one clock per output slot. `rxValid`, `rxErr` and `rxData` change only at a clock edge that sets `nibbleCe`.
- R10: While `linkUp` is low, line bits are ignored. Carrier sense is low one clock after `linkUp` is sampled low, and the following clock presents a slot with data-valid low. When the link returns, the history restarts as all idle.
- R11: After reset, `nibbleCe`, `rxValid`, `rxErr` and `carrierSense` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linkUp | input | 1 | Link status; low forces idle search |
| lineBits | input | LANES (2) | Recovered line bits, earliest in the top bit |
| bitCount | input | CNT_W (2) | Number of valid line bits this clock |
| nibbleCe | output | 1 | One-clock pulse per presented slot |
| rxValid | output | 1 | Frame data valid |
| rxErr | output | 1 | Error or false-carrier indication |
| rxData | output | 4 | Decoded nibble |
| carrierSense | output | 1 | High while a frame or false carrier is in progress |

## Verification
The checks assume `bitCount` never exceeds the number of bit lanes, and this assumption is itself asserted. They also assume a new carrier cannot appear in the same clock that clears a stale slot. The stimulus meets both. It draws counts of zero to two only, and sends a count of zero whenever no bit is queued, so idle gaps are exact. It also starts every error segment from a settled idle history, after the previous segment has fully drained.

// File: rtl/codeGroupPkg.sv
package codeGroupPkg;
  localparam int CODE_W = 5;
  localparam int HIST_W = 2 * CODE_W;
  localparam int NIB_W  = 4;
  localparam int PH_W   = $clog2(CODE_W);

  localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CG_R    = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_PRE   = 4'h5;
  localparam logic [NIB_W-1:0] NIB_FALSE = 4'hE;

  typedef enum logic [1:0] {
    MODE_HUNT,
    MODE_WAIT_K,
    MODE_FRAME,
    MODE_FALSE
  } rxMode_e;

  // State carried from bit to bit and from clock to clock.
  typedef struct packed {
    rxMode_e             mode;
    logic [HIST_W-1:0]   hist;
    logic [PH_W-1:0]     phase;
    logic [CODE_W-1:0]   pendCode;
    logic                pendPre;
  } rxCtx_t;

  // Strobe from the per-bit control to the output registers.
  typedef struct packed {
    logic              emit;
    logic              dv;
    logic              er;
    logic [NIB_W-1:0]  nib;
  } rxStrobe_t;

  function automatic rxCtx_t idleCtx();
    rxCtx_t c;
    c.mode     = MODE_HUNT;
    c.hist     = '1;
    c.phase    = '0;
    c.pendCode = '0;
    c.pendPre  = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/rxCodeDecode.sv
module rxCodeDecode
  import codeGroupPkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic              isData,
  output logic [NIB_W-1:0]  nibble
);
  always_comb begin
    isData = 1'b1;
    nibble = '0;
    unique case (code)
      5'b11110: nibble = 4'h0;
      5'b01001: nibble = 4'h1;
      5'b10100: nibble = 4'h2;
      5'b10101: nibble = 4'h3;
      5'b01010: nibble = 4'h4;
      5'b01011: nibble = 4'h5;
      5'b01110: nibble = 4'h6;
      5'b01111: nibble = 4'h7;
      5'b10010: nibble = 4'h8;
      5'b10011: nibble = 4'h9;
      5'b10110: nibble = 4'hA;
      5'b10111: nibble = 4'hB;
      5'b11010: nibble = 4'hC;
      5'b11011: nibble = 4'hD;
      5'b11100: nibble = 4'hE;
      5'b11101: nibble = 4'hF;
      default:  isData = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxFramer.sv
// Control: advances the receive context by one line bit and raises a
// strobe when a nibble slot is decided.
module rxFramer
  import codeGroupPkg::*;
(
  input  rxCtx_t    ctxIn,
  input  logic      bitIn,
  input  logic      bitEn,
  output rxCtx_t    ctxOut,
  output rxStrobe_t strobe
);
  logic              pendIsData;
  logic [NIB_W-1:0]  pendNib;
  logic [HIST_W-1:0] histNext;
  logic [CODE_W-1:0] newCode;
  logic              codeDone;
  logic              carrierHit;
  logic              startOk;

  rxCodeDecode u_dec (
    .code   (ctxIn.pendCode),
    .isData (pendIsData),
    .nibble (pendNib)
  );

  assign histNext   = {ctxIn.hist[HIST_W-2:0], bitIn};
  assign newCode    = histNext[CODE_W-1:0];
  assign codeDone   = (ctxIn.phase == PH_W'(CODE_W - 1));
  // A zero now, with another zero somewhere two to nine bits back.
  assign carrierHit = !histNext[0] && !(&histNext[HIST_W-1:2]);
  assign startOk    = (histNext == {CG_IDLE, CG_J});

  always_comb begin
    ctxOut = ctxIn;
    strobe = '0;
    if (bitEn) begin
      ctxOut.hist = histNext;
      if (ctxIn.mode != MODE_HUNT) begin
        ctxOut.phase = codeDone ? '0 : ctxIn.phase + PH_W'(1);
      end
      unique case (ctxIn.mode)
        MODE_HUNT: begin
          if (carrierHit) begin
            ctxOut.phase = '0;
            if (startOk) begin
              ctxOut.mode = MODE_WAIT_K;
            end else begin
              ctxOut.mode = MODE_FALSE;
              strobe.emit = 1'b1;
              strobe.er   = 1'b1;
              strobe.nib  = NIB_FALSE;
            end
          end
        end
        MODE_WAIT_K: begin
          if (codeDone) begin
            strobe.emit = 1'b1;
            if (newCode == CG_K) begin
              ctxOut.mode     = MODE_FRAME;
              ctxOut.pendCode = newCode;
              ctxOut.pendPre  = 1'b1;
              strobe.dv       = 1'b1;
              strobe.nib      = NIB_PRE;
            end else begin
              ctxOut.mode = MODE_FALSE;
              strobe.er   = 1'b1;
              strobe.nib  = NIB_FALSE;
            end
          end
        end
        MODE_FRAME: begin
          if (codeDone) begin
            strobe.emit = 1'b1;
            if (ctxIn.pendCode == CG_T && newCode == CG_R) begin
              ctxOut.mode = MODE_HUNT;
              ctxOut.hist = '1;
            end else if (!ctxIn.pendPre && ctxIn.pendCode == CG_IDLE &&
                         newCode == CG_IDLE) begin
              ctxOut.mode = MODE_HUNT;
              strobe.dv   = 1'b1;
              strobe.er   = 1'b1;
            end else begin
              strobe.dv = 1'b1;
              if (ctxIn.pendPre) begin
                strobe.nib = NIB_PRE;
              end else if (pendIsData) begin
                strobe.nib = pendNib;
              end else begin
                strobe.er = 1'b1;
              end
              ctxOut.pendCode = newCode;
              ctxOut.pendPre  = 1'b0;
            end
          end
        end
        MODE_FALSE: begin
          if (&histNext) begin
            ctxOut.mode = MODE_HUNT;
          end else if (codeDone) begin
            strobe.emit = 1'b1;
            strobe.er   = 1'b1;
            strobe.nib  = NIB_FALSE;
          end
        end
        default: ctxOut = idleCtx();
      endcase
    end
  end
endmodule

// File: rtl/rxDatapath.sv
// Datapath: context and output registers, with one control step per lane.
module rxDatapath
  import codeGroupPkg::*;
#(
  parameter int LANES = 2,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkUp,
  input  logic [LANES-1:0] lineBits,
  input  logic [CNT_W-1:0] bitCount,
  output logic             nibbleCe,
  output logic             rxValid,
  output logic             rxErr,
  output logic [NIB_W-1:0] rxData,
  output logic             carrierSense
);
  rxCtx_t    ctxQ;
  rxCtx_t    ctxD;
  rxCtx_t    chain [LANES+1];
  rxStrobe_t stepStb [LANES];
  rxStrobe_t pick;
  logic      dropNow;

  assign chain[0] = ctxQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rxFramer u_step (
      .ctxIn  (chain[i]),
      .bitIn  (lineBits[LANES-1-i]),
      .bitEn  (linkUp && (CNT_W'(i) < bitCount)),
      .ctxOut (chain[i+1]),
      .strobe (stepStb[i])
    );
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < LANES; i++) begin
      if (stepStb[i].emit) pick = stepStb[i];
    end
  end

  assign dropNow = (ctxQ.mode == MODE_HUNT) && (rxValid || rxErr) && !pick.emit;
  assign ctxD    = linkUp ? chain[LANES] : idleCtx();

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctxQ     <= idleCtx();
      nibbleCe <= 1'b0;
      rxValid  <= 1'b0;
      rxErr    <= 1'b0;
      rxData   <= '0;
    end else begin
      ctxQ     <= ctxD;
      nibbleCe <= pick.emit || dropNow;
      if (pick.emit) begin
        rxValid <= pick.dv;
        rxErr   <= pick.er;
        rxData  <= pick.nib;
      end else if (dropNow) begin
        rxValid <= 1'b0;
        rxErr   <= 1'b0;
        rxData  <= '0;
      end
    end
  end

  assign carrierSense = (ctxQ.mode != MODE_HUNT);
endmodule

// File: rtl/codeGroupRx.sv
module codeGroupRx
  import codeGroupPkg::*;
#(
  parameter int LANES = 2,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linkUp,
  input  logic [LANES-1:0] lineBits,
  input  logic [CNT_W-1:0] bitCount,
  output logic             nibbleCe,
  output logic             rxValid,
  output logic             rxErr,
  output logic [3:0]       rxData,
  output logic             carrierSense
);
  rxDatapath #(.LANES(LANES)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .linkUp       (linkUp),
    .lineBits     (lineBits),
    .bitCount     (bitCount),
    .nibbleCe     (nibbleCe),
    .rxValid      (rxValid),
    .rxErr        (rxErr),
    .rxData       (rxData),
    .carrierSense (carrierSense)
  );
endmodule

// File: rtl/codeGroupRxChecker.sv
module codeGroupRxChecker #(
  parameter int LANES = 2,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             linkUp,
  input logic [CNT_W-1:0] bitCount,
  input logic             nibbleCe,
  input logic             rxValid,
  input logic             rxErr,
  input logic [3:0]       rxData,
  input logic             carrierSense
);
  assert_legal_count_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(LANES));

  assert_preamble_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> (rxData == 4'h5 && !rxErr));

  assert_false_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (nibbleCe && rxErr && !rxValid) |-> rxData == 4'hE);

  assert_false_sense_R6: assert property (@(posedge clk) disable iff (!rstN)
    (nibbleCe && rxErr && !rxValid) |-> carrierSense);

  assert_slot_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !nibbleCe |-> $stable({rxValid, rxErr, rxData}));

  assert_link_sense_R10: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> !carrierSense);

  assert_link_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> ##1 !rxValid);
endmodule

bind codeGroupRx codeGroupRxChecker #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .linkUp       (linkUp),
  .bitCount     (bitCount),
  .nibbleCe     (nibbleCe),
  .rxValid      (rxValid),
  .rxErr        (rxErr),
  .rxData       (rxData),
  .carrierSense (carrierSense)
);

// File: tb/codeGroupRx_bench.sv
module codeGroupRx_bench;
  localparam int LANES = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       linkUp = 1'b0;
  logic [1:0] lineBits = 2'b00;
  logic [1:0] bitCount = 2'b00;
  logic       nibbleCe, rxValid, rxErr, carrierSense;
  logic [3:0] rxData;

  always #4 clk = ~clk;

  codeGroupRx #(.LANES(LANES)) u_codeGroupRx (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .lineBits(lineBits),
    .bitCount(bitCount), .nibbleCe(nibbleCe), .rxValid(rxValid),
    .rxErr(rxErr), .rxData(rxData), .carrierSense(carrierSense)
  );

  bit         bitQ[$];
  logic [5:0] expQ[$];
  string      tagQ[$];
  int checks = 0;
  int errors = 0;
  int countMode = 0;
  bit monOn = 1'b0;
  int cyc = 0;

  function automatic logic [4:0] enc(int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;
      3: return 5'b10101;  4: return 5'b01010;  5: return 5'b01011;
      6: return 5'b01110;  7: return 5'b01111;  8: return 5'b10010;
      9: return 5'b10011;  10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100;
      15: return 5'b11101; default: return 5'b00100;
    endcase
  endfunction

  localparam logic [4:0] C_I = 5'b11111, C_J = 5'b11000, C_K = 5'b10001;
  localparam logic [4:0] C_T = 5'b01101, C_R = 5'b00111, C_H = 5'b00100;

  task automatic putCode(logic [4:0] c);
    for (int b = 4; b >= 0; b--) bitQ.push_back(c[b]);
  endtask

  task automatic putIdle(int n);
    for (int k = 0; k < n; k++) bitQ.push_back(1'b1);
  endtask

  task automatic expectSlot(bit dv, bit er, logic [3:0] nib, string tag);
    expQ.push_back({dv, er, nib});
    tagQ.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Frame with data values; a negative entry stands for an H code.
  task automatic sendFrame(int vals[$], string tag);
    putCode(C_J); putCode(C_K);
    expectSlot(1, 0, 4'h5, "R2 preamble");
    expectSlot(1, 0, 4'h5, "R2 preamble");
    foreach (vals[k]) begin
      if (vals[k] < 0) begin
        putCode(C_H);
        expectSlot(1, 1, 4'h0, "R4 invalid code");
      end else begin
        putCode(enc(vals[k]));
        expectSlot(1, 0, 4'(vals[k]), tag);
      end
    end
    putCode(C_T); putCode(C_R);
    expectSlot(0, 0, 4'h0, "R5 end delimiter");
  endtask

  task automatic drain();
    wait (bitQ.size() == 0);
    repeat (20) @(negedge clk);
  endtask

  // Line driver: exact bit counts, zero when nothing is queued.
  always @(negedge clk) begin
    int n;
    n = (countMode == 0) ? int'($urandom_range(2, 0)) : countMode;
    if (n > bitQ.size()) n = bitQ.size();
    lineBits = 2'b00;
    if (n >= 1) lineBits[1] = bitQ.pop_front();
    if (n == 2) lineBits[0] = bitQ.pop_front();
    bitCount = 2'(n);
  end

  // Reference comparison on every clock.
  always @(negedge clk) begin
    logic [5:0] e;
    string t;
    if (monOn && nibbleCe) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected slot: actual %0h expected none",
                 {rxValid, rxErr, rxData});
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({rxValid, rxErr, rxData} === e, t, {rxValid, rxErr, rxData}, e);
        if (e[5:4] == 2'b01) check(carrierSense === 1'b1, "R6 sense high", carrierSense, 1);
        if (e[5:4] == 2'b00) check(carrierSense === 1'b0, "R5 sense low", carrierSense, 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int full[$];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    linkUp = 1'b1;
    @(negedge clk);
    check({nibbleCe, rxValid, rxErr, carrierSense} === 4'b0000, "R11 reset state",
          {nibbleCe, rxValid, rxErr, carrierSense}, 0);
    monOn = 1'b1;

    // R3 and R4: every data value plus one invalid code.
    for (int k = 0; k < 16; k++) full.push_back(k);
    full.insert(10, -1);
    sendFrame(full, "R3 data nibble");
    drain();

    // R1: fixed one-bit and two-bit delivery.
    countMode = 1;
    sendFrame('{10, 5, 12}, "R1 single-bit lane");
    drain();
    countMode = 2;
    sendFrame('{3, 15}, "R1 double-bit lane");
    drain();
    countMode = 0;

    // R6: three kinds of false carrier.
    putCode(5'b11010); putCode(C_I); putCode(C_I);
    expectSlot(0, 1, 4'hE, "R6 non-J start");
    expectSlot(0, 1, 4'hE, "R6 repeat");
    expectSlot(0, 0, 4'h0, "R6 clear");
    putCode(C_J); putCode(C_I); putCode(C_I);
    expectSlot(0, 1, 4'hE, "R6 J then idle");
    expectSlot(0, 0, 4'h0, "R6 clear");
    putCode(C_J); putCode(C_H); putCode(C_I); putCode(C_I);
    expectSlot(0, 1, 4'hE, "R6 J then H");
    expectSlot(0, 1, 4'hE, "R6 repeat");
    expectSlot(0, 0, 4'h0, "R6 clear");
    drain();
    check(carrierSense === 1'b0, "R6 sense after idle", carrierSense, 0);

    // R7: premature end.
    putCode(C_J); putCode(C_K); putCode(C_I); putCode(C_I);
    expectSlot(1, 0, 4'h5, "R7 preamble");
    expectSlot(1, 0, 4'h5, "R7 preamble");
    expectSlot(1, 1, 4'h0, "R7 error nibble");
    expectSlot(0, 0, 4'h0, "R7 drop valid");
    drain();

    // R8: back-to-back frames with 0..9 extra idle bits.
    for (int i = 0; i < 10; i++) begin
      sendFrame('{}, "R8 spacing");
      putIdle(i);
    end
    drain();

    // R10: link loss mid-frame, then bits ignored while down.
    putCode(C_J); putCode(C_K); putCode(enc(0)); putCode(enc(1));
    expectSlot(1, 0, 4'h5, "R10 preamble");
    expectSlot(1, 0, 4'h5, "R10 preamble");
    expectSlot(1, 0, 4'h0, "R10 data");
    expectSlot(0, 0, 4'h0, "R10 drop valid");
    drain();
    check(carrierSense === 1'b1, "R10 sense before loss", carrierSense, 1);
    linkUp = 1'b0;
    @(negedge clk);
    check(carrierSense === 1'b0, "R10 sense after loss", carrierSense, 0);
    @(negedge clk);
    check(rxValid === 1'b0, "R10 valid after loss", rxValid, 0);
    putCode(C_J); putCode(C_K); putCode(enc(7)); putCode(C_T); putCode(C_R);
    drain();
    check(carrierSense === 1'b0, "R10 bits ignored", carrierSense, 0);
    linkUp = 1'b1;
    @(negedge clk);
    sendFrame('{1, 2}, "R10 after relink");
    drain();

    check(expQ.size() == 0, "R9 all slots seen", expQ.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule